// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block produces the count-enable pulses for two timer/counters that run from one system I/O clock. A single free-running 10-bit prescaler counter supplies divided clock-enable taps. Each timer has its own 3-bit clock-select input. The select picks one of these sources: no clock, every cycle, one of four prescaled taps, or a rising or falling edge on that timer's own external pin. Each timer receives one output pulse, one cycle wide, for each tick of the chosen source.

The prescaler has no reset input of its own. Software clears it by writing a control byte in which bit 0 is one. The clear acts on the clock edge that accepts the write, and nothing is held afterwards. Because the counter is shared, the clear restarts the prescaled ticks of both timers together. An external pin is sampled on the system clock through a two-flop synchronizer and an edge register, and it never passes through the prescaler. Edges on the pin can be resolved only while the external clock runs slower than half the system clock at 50% duty cycle.

Top module: `tmr_psc_share`

## Requirements
- R1: While `rst_n` is low the prescaler count is held at zero. With select 2 (divide-by-8), the first pulse is in the eighth cycle after reset is released, counting the cycle in which release is first seen as the first.
- R2: Select 0 never produces a count-enable pulse.
- R3: Select 1 produces a count enable in every cycle.
- R4: Selects 2, 3, 4 and 5 give one-cycle pulses with periods of 8, 64, 256 and 1024 cycles. A tap fires in the cycle where the low 3, 6, 8 or 10 bits of the count are all ones.
- R5: In any 1024-cycle window that starts at a prescaler clear, the taps give exactly 128, 16, 4 and 1 pulses.
- R6: A write (`ctl_wr` high) with bit 0 of `ctl_wdata` set clears the shared count on that edge. The prescaled pulse with period N then appears N-1 cycles after the write edge, in phase on both timers, and counting continues on its own afterwards.
- R7: A write with bit 0 clear, or bit 0 set while `ctl_wr` is low, leaves the prescaler count and the timing of its pulses unchanged.
- R8: Select 7 gives exactly one pulse per rising edge on the timer's pin, and select 6 gives exactly one pulse per falling edge. The pulse appears in the cycle after the second system-clock edge that follows the pin change.
- R9: Pulses from an external-pin selection do not depend on prescaler clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte; bit 0 set requests a prescaler clear |
| t0_sel | input | 3 | Clock select for timer 0 |
| t1_sel | input | 3 | Clock select for timer 1 |
| t0_pin | input | 1 | External clock pin for timer 0 |
| t1_pin | input | 1 | External clock pin for timer 1 |
| t0_cnt_en | output | 1 | One-cycle count enable for timer 0 |
| t1_cnt_en | output | 1 | One-cycle count enable for timer 1 |

## Verification
A clear takes effect on its write edge, so the bench takes the sample in the half cycle right after that edge as count 0. A tap of period N is then due at sample N-1 and every N samples after it. Every window count and every phase check starts from a clear made in this way. For an external pin, the bench changes the pin at a falling clock edge. The pulse is expected at the second falling edge after that, and the bench checks that the output is low at the falling edges just before and just after. All outputs are sampled at falling edges, half a period away from the edges at which the registers update.

// File: rtl/tmr_psc_share.sv
module tmr_psc_share #(
  parameter int PSC_W = 10,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic [SEL_W-1:0] t0_sel,
  input  logic [SEL_W-1:0] t1_sel,
  input  logic             t0_pin,
  input  logic             t1_pin,
  output logic             t0_cnt_en,
  output logic             t1_cnt_en
);

  localparam int NTAP = 4;
  localparam int TAP_BITS [NTAP] = '{3, 6, 8, PSC_W};

  logic [PSC_W-1:0] psc_cnt;
  logic [NTAP-1:0]  tap;
  logic             psc_clr;

  assign psc_clr = ctl_wr & ctl_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       psc_cnt <= '0;
    else if (psc_clr) psc_cnt <= '0;
    else              psc_cnt <= psc_cnt + 1'b1;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap[i] = &psc_cnt[TAP_BITS[i]-1:0];
  end

  logic [1:0][SEL_W-1:0] sel;
  logic [1:0]            pin;
  logic [1:0]            en;

  assign sel = {t1_sel, t0_sel};
  assign pin = {t1_pin, t0_pin};
  assign t0_cnt_en = en[0];
  assign t1_cnt_en = en[1];

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic s1, s2, s3, rise, fall;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) {s1, s2, s3} <= '0;
      else        {s1, s2, s3} <= {pin[t], s1, s2};

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;

    always_comb
      unique case (sel[t])
        3'd0:    en[t] = 1'b0;
        3'd1:    en[t] = 1'b1;
        3'd2:    en[t] = tap[0];
        3'd3:    en[t] = tap[1];
        3'd4:    en[t] = tap[2];
        3'd5:    en[t] = tap[3];
        3'd6:    en[t] = fall;
        default: en[t] = rise;
      endcase

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[t] && sel[t][2:1] == 2'b11) |=> (!en[t] || sel[t] != $past(sel[t]))); // R8
    AST_EXT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[t] == 3'd7 && $stable(sel[t]) && rise) |-> $past(pin[t], 2) && !$past(pin[t], 3)); // R8
  end

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    psc_clr |=> (psc_cnt == '0)); // R6
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_wdata[0]) |=> (psc_cnt == $past(psc_cnt) + 1'b1)); // R7
  AST_DIV8_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tap[0] |=> !tap[0]); // R4

endmodule

// File: tb/tmr_psc_share_test.sv
module tmr_psc_share_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [2:0] t0_sel = 3'd0, t1_sel = 3'd0;
  logic       t0_pin = 1'b0, t1_pin = 1'b0;
  logic       t0_cnt_en, t1_cnt_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_psc_share uut (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .t0_sel, .t1_sel,
    .t0_pin, .t1_pin, .t0_cnt_en, .t1_cnt_en
  );

  localparam int NV = 8;
  localparam logic [2:0] VS0 [NV] = '{3'd0, 3'd2, 3'd4, 3'd5, 3'd1, 3'd6, 3'd3, 3'd5};
  localparam logic [2:0] VS1 [NV] = '{3'd1, 3'd3, 3'd5, 3'd2, 3'd0, 3'd7, 3'd4, 3'd5};
  localparam int VE0 [NV] = '{0, 128, 4, 1, 1024, 0, 16, 1};
  localparam int VE1 [NV] = '{1024, 16, 1, 128, 0, 0, 4, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h01;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: first divide-by-8 pulse after reset release
    t0_sel = 3'd2; t1_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk(!t0_cnt_en && !t1_cnt_en, "R1 quiet in reset", t0_cnt_en, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk(t0_cnt_en == (k == 7), "R1 first tap", t0_cnt_en, k == 7);
      @(negedge clk);
    end

    // R2 R3 R4 R5: table of select pairs, pulses counted over 1024 cycles
    for (int v = 0; v < NV; v++) begin
      int c0, c1;
      t0_sel = VS0[v]; t1_sel = VS1[v];
      c0 = 0; c1 = 0;
      do_clear();
      for (int k = 0; k < 1024; k++) begin
        c0 += int'(t0_cnt_en); c1 += int'(t1_cnt_en);
        @(negedge clk);
      end
      chk(c0 == VE0[v], "R5 window count t0", c0, VE0[v]);
      chk(c1 == VE1[v], "R5 window count t1", c1, VE1[v]);
    end

    // R4: divide-by-64 period and width
    t0_sel = 3'd3; t1_sel = 3'd0;
    do_clear();
    for (int k = 0; k < 200; k++) begin
      if ((k % 64) == 63 || (k % 64) == 0)
        chk(t0_cnt_en == ((k % 64) == 63), "R4 div64 phase", t0_cnt_en, (k % 64) == 63);
      @(negedge clk);
    end

    // R6: clear in mid-count restarts both timers in phase
    t0_sel = 3'd3; t1_sel = 3'd2;
    do_clear();
    repeat (20) @(negedge clk);
    do_clear();
    for (int k = 0; k < 64; k++) begin
      if (k == 63)
        chk(t0_cnt_en && t1_cnt_en, "R6 both in phase", {t0_cnt_en, t1_cnt_en}, 3);
      else if (t0_cnt_en)
        chk(0, "R6 early div64", 1, 0);
      if ((k % 8) == 7)
        chk(t1_cnt_en, "R6 div8 after clear", t1_cnt_en, 1);
      @(negedge clk);
    end

    // R7: zero-bit write and bit-set without strobe leave prescaler alone
    t0_sel = 3'd2; t1_sel = 3'd2;
    do_clear();
    for (int k = 0; k < 16; k++) begin
      ctl_wr = (k == 2); ctl_wdata = (k == 2) ? 8'hFE : (k == 4) ? 8'h01 : 8'h00;
      if (k == 7 || k == 15)
        chk(t0_cnt_en && t1_cnt_en, "R7 no effect", t0_cnt_en, 1);
      else if (k == 3 || k == 6)
        chk(!t0_cnt_en, "R7 no early tap", t0_cnt_en, 0);
      @(negedge clk);
    end
    ctl_wr = 1'b0; ctl_wdata = 8'h00;

    // R8: pulse latency for rising (t0) and falling (t1) selects
    t0_sel = 3'd7; t1_sel = 3'd6;
    t0_pin = 1'b0; t1_pin = 1'b1;
    repeat (4) @(negedge clk);
    t0_pin = 1'b1; t1_pin = 1'b0;
    @(negedge clk);
    chk(!t0_cnt_en && !t1_cnt_en, "R8 not yet", t0_cnt_en, 0);
    @(negedge clk);
    chk(t0_cnt_en && t1_cnt_en, "R8 edge pulse", {t0_cnt_en, t1_cnt_en}, 3);
    @(negedge clk);
    chk(!t0_cnt_en && !t1_cnt_en, "R8 single cycle", t0_cnt_en, 0);

    // R8 R9: count edges with prescaler clears mixed in
    begin
      int c0, c1;
      c0 = 0; c1 = 0;
      t0_pin = 1'b0; t1_pin = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 48; k++) begin
        if (k % 4 == 0 && k < 40) begin t0_pin = ~t0_pin; t1_pin = ~t1_pin; end
        ctl_wr = (k % 5 == 1); ctl_wdata = 8'h01;
        @(negedge clk);
        c0 += int'(t0_cnt_en); c1 += int'(t1_cnt_en);
      end
      ctl_wr = 1'b0; ctl_wdata = 8'h00;
      chk(c0 == 5, "R8 R9 rising edges", c0, 5);
      chk(c1 == 5, "R8 R9 falling edges", c1, 5);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule